// File: doc/BRIEF.md
# Addend-Compensated Nanosecond Time Counter

This block keeps a 64-bit time of day in nanoseconds. A reference strobe, picked from four enable inputs by a 2-bit source field, drives a 32-bit fractional phase accumulator. On each selected strobe the accumulator adds a programmable addend. Every carry out of the accumulator is one nominal tick. On each tick the time counter advances by a programmable whole-nanosecond period. Because the tick rate is the reference rate scaled by addend / 2^32, software can trim the frequency in fine steps by rewriting the addend. The addend is the ceiling of 2^32 divided by the ratio of reference frequency to nominal frequency. That ratio must be above 1, so the addend stays below 2^32 and no reference cycle yields more than one tick.

A prescaler counts ticks and gives a one-cycle output clock enable once every N ticks. For example, a 10 ns period gives a 100 MHz nominal rate, and a prescale of 100 turns that into a 1 MHz enable. A small register file sets the source, addend, period and prescale, preloads the counter in two word writes, and reads the counter back. Reading the low word freezes a copy of the high word, so a 64-bit read is never torn.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the source field is 1 (system clock), the addend is 0x999999A4, the period is 10, the prescale is 100, the time reads 0 and the output enable is low.
- R2: Starting from a cleared accumulator, n selected strobes with addend a produce floor(n*a / 2^32) ticks, with at most one tick per strobe.
- R3: A tick registered at one edge adds the period to the time counter at the following edge; without a tick or a preload the time holds.
- R4: Writing address 4 stages a low word; writing address 5 loads {written word, staged word} into the time counter at that edge, overriding a tick in the same cycle.
- R5: The output enable is a one-cycle pulse after every prescale-th tick; a prescale of 0 or 1 gives a pulse after every tick.
- R6: Only the enable input indexed by the source field (bits 1:0 of address 0; 0 external, 1 system, 2 alternate, 3 RTC) advances the accumulator; the other three inputs are ignored.
- R7: A new addend applies from the next selected strobe and leaves the accumulator value intact.
- R8: Reading address 6 with the read strobe returns the low time word and freezes the high word; address 7 returns that frozen high word until the next such read.
- R9: Addresses 0 to 3 read back source, addend, period and prescale; address 4 reads the staged low word and address 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en_i | input | 4 | Reference strobes, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (freezes the high word on a low-word read) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational on rd_addr |
| out_en_o | output | 1 | Prescaled output clock enable |

## Verification
The checker watches, on every cycle, that a tick follows a selected strobe and that the counter either steps by exactly one period, takes a preload, or holds. It also checks that the output enable only follows a tick. The bench covers what a single cycle cannot show. It counts ticks over whole strobe runs against the floor formula and counts enable pulses for several prescale values, including 0. It also checks that the counter keeps its fractional phase across an addend rewrite, that unselected sources are ignored, and that a preload wins over a tick in the same cycle.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    localparam int ACC_W  = 32;
    localparam int TIME_W = 64;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int PER_W  = 16;
    localparam int PRE_W  = 16;
    localparam int NSRC   = 4;
    localparam int SEL_W  = $clog2(NSRC);

    typedef enum logic [SEL_W-1:0] {
        SRC_EXT = 2'd0,
        SRC_SYS = 2'd1,
        SRC_ALT = 2'd2,
        SRC_RTC = 2'd3
    } src_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_ADDEND = 3'd1,
        A_PERIOD = 3'd2,
        A_PRESC  = 3'd3,
        A_LDLO   = 3'd4,
        A_LDHI   = 3'd5,
        A_TLO    = 3'd6,
        A_THI    = 3'd7
    } addr_e;

    typedef struct packed {
        src_e              src;
        logic [ACC_W-1:0]  addend;
        logic [PER_W-1:0]  period;
        logic [PRE_W-1:0]  presc;
    } cfg_t;

    // A prescale of 0 or 1 fires on every tick; a count at or past the
    // terminal value also fires so a lowered prescale never stalls.
    function automatic logic presc_hit(input logic [PRE_W-1:0] cnt,
                                       input logic [PRE_W-1:0] presc);
        if (presc <= PRE_W'(1))
            return 1'b1;
        return cnt >= (presc - PRE_W'(1));
    endfunction

endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
    import ptp_tc_pkg::*;
#(
    parameter logic [ACC_W-1:0] ADDEND_RST = 32'h9999_99A4,
    parameter logic [PER_W-1:0] PERIOD_RST = 16'd10,
    parameter logic [PRE_W-1:0] PRESC_RST  = 16'd100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [TIME_W-1:0] time_i,
    output cfg_t              cfg_o,
    output logic              load_o,
    output logic [TIME_W-1:0] load_val_o
);
    localparam int HI_W = TIME_W - REG_W;

    cfg_t             cfg_q;
    logic [REG_W-1:0] stage_lo_q;
    logic [HI_W-1:0]  hi_frozen_q;
    logic             wr_hit_ldhi;
    logic             rd_hit_tlo;

    assign wr_hit_ldhi = wr_en && (addr_e'(wr_addr) == A_LDHI);
    assign rd_hit_tlo  = rd_en && (addr_e'(rd_addr) == A_TLO);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.src    <= SRC_SYS;
            cfg_q.addend <= ADDEND_RST;
            cfg_q.period <= PERIOD_RST;
            cfg_q.presc  <= PRESC_RST;
            stage_lo_q   <= '0;
            hi_frozen_q  <= '0;
        end else begin
            if (wr_en) begin
                case (addr_e'(wr_addr))
                    A_CTRL:   cfg_q.src    <= src_e'(wr_data[SEL_W-1:0]);
                    A_ADDEND: cfg_q.addend <= wr_data[ACC_W-1:0];
                    A_PERIOD: cfg_q.period <= wr_data[PER_W-1:0];
                    A_PRESC:  cfg_q.presc  <= wr_data[PRE_W-1:0];
                    A_LDLO:   stage_lo_q   <= wr_data;
                    default:  ;
                endcase
            end
            if (rd_hit_tlo)
                hi_frozen_q <= time_i[TIME_W-1:REG_W];
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr_e'(rd_addr))
            A_CTRL:   rd_data = REG_W'(cfg_q.src);
            A_ADDEND: rd_data = REG_W'(cfg_q.addend);
            A_PERIOD: rd_data = REG_W'(cfg_q.period);
            A_PRESC:  rd_data = REG_W'(cfg_q.presc);
            A_LDLO:   rd_data = stage_lo_q;
            A_LDHI:   rd_data = '0;
            A_TLO:    rd_data = time_i[REG_W-1:0];
            A_THI:    rd_data = REG_W'(hi_frozen_q);
            default:  rd_data = '0;
        endcase
    end

    assign cfg_o      = cfg_q;
    assign load_o     = wr_hit_ldhi;
    assign load_val_o = {wr_data[HI_W-1:0], stage_lo_q};

endmodule

// File: rtl/ptp_tc_phase_acc.sv
module ptp_tc_phase_acc
    import ptp_tc_pkg::*;
#(
    parameter int W  = ACC_W,
    parameter int NS = NSRC,
    localparam int SW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] ref_en_i,
    input  logic [SW-1:0] sel_i,
    input  logic [W-1:0]  addend_i,
    output logic          ref_en_o,
    output logic          tick_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;
    logic         tick_q;
    logic [NS-1:0] src_onehot;

    // Enable mux built as a one-hot AND-OR so each source is a leaf gate.
    for (genvar s = 0; s < NS; s++) begin : g_src
        assign src_onehot[s] = (sel_i == SW'(s)) && ref_en_i[s];
    end

    assign ref_en_o = |src_onehot;
    assign sum      = {1'b0, acc_q} + {1'b0, addend_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (ref_en_o) begin
                acc_q  <= sum[W-1:0];
                tick_q <= sum[W];
            end
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/ptp_tc_tod.sv
module ptp_tc_tod
    import ptp_tc_pkg::*;
#(
    parameter int TW = TIME_W,
    parameter int PW = PER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [PW-1:0] period_i,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic [TW-1:0] time_o
);
    logic [TW-1:0] time_q;

    always_ff @(posedge clk) begin
        if (rst)
            time_q <= '0;
        else if (load_i)
            time_q <= load_val_i;
        else if (tick_i)
            time_q <= time_q + TW'(period_i);
    end

    assign time_o = time_q;

endmodule

// File: rtl/ptp_tc_presc.sv
module ptp_tc_presc
    import ptp_tc_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [PW-1:0] presc_i,
    output logic          out_en_o
);
    logic [PW-1:0] cnt_q;
    logic          out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            out_q <= 1'b0;
            if (tick_i) begin
                if (presc_hit(cnt_q, presc_i)) begin
                    cnt_q <= '0;
                    out_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + PW'(1);
                end
            end
        end
    end

    assign out_en_o = out_q;

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter logic [ACC_W-1:0] ADDEND_RST = 32'h9999_99A4,
    parameter logic [PER_W-1:0] PERIOD_RST = 16'd10,
    parameter logic [PRE_W-1:0] PRESC_RST  = 16'd100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   ref_en_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              out_en_o
);
    cfg_t              cfg;
    logic              load_fire;
    logic [TIME_W-1:0] load_val;
    logic [TIME_W-1:0] time_q;
    logic              ref_en;
    logic              tick;
    logic [PER_W-1:0]  period_q;

    assign period_q = cfg.period;

    ptp_tc_regs #(
        .ADDEND_RST (ADDEND_RST),
        .PERIOD_RST (PERIOD_RST),
        .PRESC_RST  (PRESC_RST)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .time_i     (time_q),
        .cfg_o      (cfg),
        .load_o     (load_fire),
        .load_val_o (load_val)
    );

    ptp_tc_phase_acc #(.W(ACC_W), .NS(NSRC)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .ref_en_i (ref_en_i),
        .sel_i    (cfg.src),
        .addend_i (cfg.addend),
        .ref_en_o (ref_en),
        .tick_o   (tick)
    );

    ptp_tc_tod #(.TW(TIME_W), .PW(PER_W)) u_tod (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .period_i   (period_q),
        .load_i     (load_fire),
        .load_val_i (load_val),
        .time_o     (time_q)
    );

    ptp_tc_presc #(.PW(PRE_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .presc_i  (cfg.presc),
        .out_en_o (out_en_o)
    );

endmodule

// File: rtl/ptp_tc_chk.sv
module ptp_tc_chk
    import ptp_tc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ref_en,
    input logic              tick,
    input logic              out_en,
    input logic              load_fire,
    input logic [TIME_W-1:0] load_val,
    input logic [TIME_W-1:0] time_q,
    input logic [PER_W-1:0]  period
);
    // R2
    tick_src_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(ref_en));

    // R3
    tod_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_fire) |=> (time_q == $past(time_q) + TIME_W'($past(period))));

    // R3
    tod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_fire) |=> $stable(time_q));

    // R4
    preload_chk: assert property (@(posedge clk) disable iff (rst)
        load_fire |=> (time_q == $past(load_val)));

    // R5
    outen_src_chk: assert property (@(posedge clk) disable iff (rst)
        out_en |-> $past(tick));

endmodule

bind ptp_time_counter ptp_tc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_en    (ref_en),
    .tick      (tick),
    .out_en    (out_en_o),
    .load_fire (load_fire),
    .load_val  (load_val),
    .time_q    (time_q),
    .period    (period_q)
);

// File: tb/sim_ptp_time_counter.sv
`timescale 1ns/1ps
module sim_ptp_time_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ref_en_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        out_en_o;

    int errors = 0;
    int checks = 0;
    int outs = 0;
    logic count_en = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    ptp_time_counter u0 (
        .clk      (clk),
        .rst      (rst),
        .ref_en_i (ref_en_i),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .out_en_o (out_en_o)
    );

    always @(negedge clk)
        if (count_en && out_en_o) outs++;

    typedef struct packed {
        logic [31:0] addend;
        logic [15:0] period;
        logic [15:0] presc;
        logic [15:0] n;
        logic [63:0] exp_time;
        logic [15:0] exp_outs;
    } vec_t;

    // ticks = floor(n*addend/2^32); time = ticks*period; outs = floor(ticks/max(presc,1))
    localparam vec_t VECS [6] = '{
        '{32'h8000_0000, 16'd10, 16'd2,   16'd10,  64'd50,  16'd2},
        '{32'h9999_99A4, 16'd10, 16'd100, 16'd100, 64'd600, 16'd0},
        '{32'h9999_99A4, 16'd10, 16'd6,   16'd100, 64'd600, 16'd10},
        '{32'h4000_0000, 16'd3,  16'd1,   16'd7,   64'd3,   16'd1},
        '{32'hFFFF_FFFF, 16'd7,  16'd0,   16'd5,   64'd28,  16'd4},
        '{32'h0000_0001, 16'd10, 16'd1,   16'd20,  64'd0,   16'd0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_en_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic read_time(output logic [63:0] t);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'd6;
        #1 t[31:0] = rd_data;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 3'd7;
        #1 t[63:32] = rd_data;
    endtask

    task automatic pulse(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_en_i[idx] = 1'b1;
            @(negedge clk); ref_en_i[idx] = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] t;

        // R1 / R9: reset values read through the register map
        do_reset();
        rd(3'd0, d); check("R1 src", d, 1);
        rd(3'd1, d); check("R1 addend", d, 32'h9999_99A4);
        rd(3'd2, d); check("R1 period", d, 10);
        rd(3'd3, d); check("R1 presc", d, 100);
        rd(3'd5, d); check("R9 ldhi reads 0", d, 0);
        read_time(t); check("R1 time", t, 0);
        check("R1 out_en", {63'd0, out_en_o}, 0);

        // R2 / R3 / R5: vector table on the default system source
        foreach (VECS[k]) begin
            do_reset();
            wr(3'd1, VECS[k].addend);
            wr(3'd2, {16'd0, VECS[k].period});
            wr(3'd3, {16'd0, VECS[k].presc});
            outs = 0; count_en = 1'b1;
            pulse(1, int'(VECS[k].n));
            count_en = 1'b0;
            read_time(t);
            check("R2_R3 time", t, VECS[k].exp_time);
            check("R5 outs", 64'(outs), 64'(VECS[k].exp_outs));
        end

        // R6: unselected sources are ignored
        do_reset();
        wr(3'd1, 32'h8000_0000);
        wr(3'd2, 32'd1);
        wr(3'd0, 32'd2);
        pulse(1, 6); pulse(0, 6); pulse(3, 6);
        read_time(t); check("R6 ignored", t, 0);
        pulse(2, 4);
        read_time(t); check("R6 selected", t, 2);

        // R7: addend rewrite keeps accumulated phase
        do_reset();
        wr(3'd1, 32'h8000_0000);
        wr(3'd2, 32'd10);
        pulse(1, 1);
        wr(3'd1, 32'h4000_0000);
        pulse(1, 2);
        read_time(t); check("R7 phase kept", t, 10);

        // R4: preload wins over a tick in the same cycle
        do_reset();
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'd5);
        wr(3'd4, 32'h0000_1000);
        rd(3'd4, d); check("R9 ldlo readback", d, 32'h1000);
        @(negedge clk); ref_en_i[1] = 1'b1;
        repeat (6) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'd0; rd_addr = 3'd6;
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R4 preload priority", rd_data, 32'h1000);
        @(negedge clk);
        #1 check("R4 tick after load", rd_data, 32'h1005);
        ref_en_i = '0;

        // R8: high word frozen at low-word read
        do_reset();
        wr(3'd4, 32'h5);
        wr(3'd5, 32'hA);
        read_time(t); check("R8 full read", t, 64'h0000_000A_0000_0005);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'hB);
        rd(3'd7, d); check("R8 frozen hi", d, 32'hA);
        read_time(t); check("R8 new read", t, 64'h0000_000B_0000_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule